// File: doc/BRIEF.md
# Multi-channel DMA start and redirect control

This block sits beside a six-channel, descriptor-chained DMA engine and turns writes to its global control word into per-channel actions. Setting a bit in the low group of the word launches the matching channel with a single-cycle start pulse. Setting a bit in the next group arms a redirect for the matching channel. That request is not acted on at once: it is held in a sticky per-channel flag until the channel next signals the end of a frame.

At each end-of-frame event the block decides where the channel fetches its next descriptor. Normally it follows the chain and picks the link address carried by the current descriptor. If a redirect is pending, it picks the channel's programmed start address instead and consumes the flag. The chosen address comes out one cycle after the event, with a valid strobe and a marker that says which source was used. Every control bit is write-only and clears itself, so a read of the word always returns zero. The asynchronous reset is released through a two-stage synchronizer.

Top module: `dma_trig_redirect`

## Requirements
- R1: While reset is held, and until the first write or frame end after it, every start pulse, pending flag, fetch strobe, fetch-source marker, fetch address and read data bit is 0.
- R2: A write with bit i set (i = 0..5 selects channel i) drives start_pulse[i] high in the cycle after the write. The pulse lasts one cycle unless the next cycle carries another such write.
- R3: Bits written as 0, and any cycle with wr_en low, cause no start pulse and do not change any pending flag.
- R4: A write with bit 6+i set (i = 0..5) sets redir_pending[i] in the cycle after the write. The flag stays set until it is consumed.
- R5: When eof[i] is high, fetch_valid[i] is high in the next cycle and lasts one cycle. Without a pending redirect, fetch_addr for channel i is the next_addr value of channel i sampled in the eof cycle, and fetch_redirect[i] is 0.
- R6: When eof[i] is high while redir_pending[i] is set, the next cycle shows fetch_addr equal to the start_addr of channel i sampled in the eof cycle, with fetch_redirect[i] = 1. The flag is cleared in that same cycle.
- R7: A redirect write for channel i in the same cycle as an eof[i] that consumes the flag leaves redir_pending[i] set for the following frame. A redirect write that coincides with an eof[i] while no flag is pending does not affect that fetch.
- R8: rd_data is 0 in the cycle after any read. Bits 12 to 31 of a write have no effect on any output.
- R9: Channels act independently: a write bit or eof for one channel never changes another channel's pulse, flag or fetch outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| rd_en | input | 1 | Control word read strobe |
| rd_data | output | 32 | Read data, registered, always zero |
| eof | input | 6 | Per-channel end-of-frame event |
| next_addr | input | 192 | Per-channel link address from the current descriptor, channel i at bits 32i+31:32i |
| start_addr | input | 192 | Per-channel programmed start address, same packing |
| start_pulse | output | 6 | Per-channel one-cycle start pulse |
| redir_pending | output | 6 | Per-channel sticky redirect flag |
| fetch_valid | output | 6 | Per-channel strobe: fetch address decided |
| fetch_redirect | output | 6 | Per-channel marker: start address was chosen |
| fetch_addr | output | 192 | Per-channel chosen next-descriptor address, same packing |

## Verification
A stuck or lost redirect flag shows up on redir_pending the cycle after the write or the eof that should have changed it. It also shows up at the very next frame end of that channel, as the wrong fetch source and address one cycle after eof. A start pulse that is stretched, delayed or sent to the wrong channel is visible on the first cycle after the write. The bench runs a behavioural model that tracks each channel's flag and the expected outputs, and compares them on every clock. Directed sequences cover the collision of a redirect write with a consuming eof, writes to the reserved bits only, and a redirect on one channel while all channels end their frames together.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

  // Source of the next descriptor address chosen at frame end
  typedef enum logic {
    SRC_LINK  = 1'b0,
    SRC_START = 1'b1
  } fetch_src_e;

  // Bit position of the first trigger and first redirect field
  function automatic int unsigned trig_lsb();
    return 0;
  endfunction

  function automatic int unsigned redir_lsb(input int unsigned num_ch);
    return num_ch;
  endfunction

endpackage

// File: rtl/dma_ctl_wr_decode.sv
module dma_ctl_wr_decode #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_CH-1:0] trig_pulse,
  output logic [NUM_CH-1:0] redir_req
);
  import dma_ctl_pkg::*;

  localparam int unsigned TRG_LO = trig_lsb();
  localparam int unsigned RDR_LO = redir_lsb(NUM_CH);

  logic [NUM_CH-1:0] trig_d;
  logic [NUM_CH-1:0] trig_q;

  // Redirect requests go straight to the channel flags; triggers are registered
  always_comb begin
    trig_d    = '0;
    redir_req = '0;
    if (wr_en) begin
      trig_d    = wr_data[TRG_LO +: NUM_CH];
      redir_req = wr_data[RDR_LO +: NUM_CH];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
    end else begin
      trig_q <= trig_d;
    end
  end

  assign trig_pulse = trig_q;

endmodule

// File: rtl/dma_ctl_chan.sv
module dma_ctl_chan #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir_req,
  input  logic              eof,
  input  logic [ADDR_W-1:0] next_addr,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              pending,
  output logic              fetch_valid,
  output logic              fetch_redirect,
  output logic [ADDR_W-1:0] fetch_addr
);
  import dma_ctl_pkg::*;

  logic              pend_q, pend_d;
  logic              fv_q, fv_d;
  fetch_src_e        src_q, src_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  // Sticky flag: consumed by eof, a new request in the same cycle re-arms it
  always_comb begin
    pend_d = pend_q;
    if (eof)       pend_d = 1'b0;
    if (redir_req) pend_d = 1'b1;
  end

  always_comb begin
    fv_d    = eof;
    addr_en = eof;
    src_d   = src_q;
    addr_d  = addr_q;
    if (addr_en) begin
      src_d  = pend_q ? SRC_START : SRC_LINK;
      addr_d = pend_q ? start_addr : next_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      fv_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      fv_q   <= fv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_LINK;
      addr_q <= '0;
    end else if (addr_en) begin
      src_q  <= src_d;
      addr_q <= addr_d;
    end
  end

  assign pending        = pend_q;
  assign fetch_valid    = fv_q;
  assign fetch_redirect = (src_q == SRC_START);
  assign fetch_addr     = addr_q;

endmodule

// File: rtl/dma_ctl_readback.sv
module dma_ctl_readback #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned IMPL_W = 2 * NUM_CH;

  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] rd_d, rd_q;

  // Implemented fields are write-only, the rest is reserved: both read as zero
  always_comb begin
    word = '0;
    word[IMPL_W-1:0] = '0;
    rd_d = rd_en ? word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/dma_trig_redirect.sv
module dma_trig_redirect #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     rd_en,
  output logic [DATA_W-1:0]        rd_data,
  input  logic [NUM_CH-1:0]        eof,
  input  logic [NUM_CH*ADDR_W-1:0] next_addr,
  input  logic [NUM_CH*ADDR_W-1:0] start_addr,
  output logic [NUM_CH-1:0]        start_pulse,
  output logic [NUM_CH-1:0]        redir_pending,
  output logic [NUM_CH-1:0]        fetch_valid,
  output logic [NUM_CH-1:0]        fetch_redirect,
  output logic [NUM_CH*ADDR_W-1:0] fetch_addr
);

  logic              rst_meta_q;
  logic              rst_sync_n;
  logic [NUM_CH-1:0] redir_req;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  dma_ctl_wr_decode #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
  ) u_decode (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .trig_pulse (start_pulse),
    .redir_req  (redir_req)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    dma_ctl_chan #(
      .ADDR_W (ADDR_W)
    ) u_chan (
      .clk            (clk),
      .rst_n          (rst_sync_n),
      .redir_req      (redir_req[g]),
      .eof            (eof[g]),
      .next_addr      (next_addr[g*ADDR_W +: ADDR_W]),
      .start_addr     (start_addr[g*ADDR_W +: ADDR_W]),
      .pending        (redir_pending[g]),
      .fetch_valid    (fetch_valid[g]),
      .fetch_redirect (fetch_redirect[g]),
      .fetch_addr     (fetch_addr[g*ADDR_W +: ADDR_W])
    );
  end

  dma_ctl_readback #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
  ) u_readback (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_en   (rd_en),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/dma_trig_redirect_chk.sv
module dma_trig_redirect_chk #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [NUM_CH-1:0] eof,
  input logic [NUM_CH-1:0] start_pulse,
  input logic [NUM_CH-1:0] redir_pending,
  input logic [NUM_CH-1:0] fetch_valid,
  input logic [NUM_CH-1:0] fetch_redirect
);

  AST_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data == '0); // R8

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse[i] |-> $past(rst_n) && $past(wr_en && wr_data[i])); // R2

    AST_PULSE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[i]) |=> start_pulse[i]); // R2

    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[NUM_CH+i]) |=> redir_pending[i]); // R4

    AST_PEND_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
      (eof[i] && !(wr_en && wr_data[NUM_CH+i])) |=> !redir_pending[i]); // R6

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (redir_pending[i] && !eof[i]) |=> redir_pending[i]); // R4

    AST_FETCH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      eof[i] |=> fetch_valid[i]); // R5

    AST_FETCH_ONLY_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid[i] |-> $past(rst_n) && $past(eof[i])); // R5

    AST_FETCH_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (eof[i] && redir_pending[i]) |=> fetch_redirect[i]); // R6

    AST_FETCH_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      (eof[i] && !redir_pending[i]) |=> !fetch_redirect[i]); // R5
  end

endmodule

bind dma_trig_redirect dma_trig_redirect_chk #(
  .NUM_CH (NUM_CH),
  .DATA_W (DATA_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .wr_en          (wr_en),
  .wr_data        (wr_data),
  .rd_data        (rd_data),
  .eof            (eof),
  .start_pulse    (start_pulse),
  .redir_pending  (redir_pending),
  .fetch_valid    (fetch_valid),
  .fetch_redirect (fetch_redirect)
);

// File: tb/dma_trig_redirect_tb.sv
`timescale 1ns/1ps
module dma_trig_redirect_tb;
  localparam int NCH = 6;
  localparam int AW  = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [31:0]       wr_data = '0;
  logic              rd_en = 1'b0;
  logic [31:0]       rd_data;
  logic [NCH-1:0]    eof = '0;
  logic [NCH*AW-1:0] next_addr = '0;
  logic [NCH*AW-1:0] start_addr = '0;
  logic [NCH-1:0]    start_pulse, redir_pending, fetch_valid, fetch_redirect;
  logic [NCH*AW-1:0] fetch_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit model_on = 0;

  always #2.5 clk = ~clk;

  dma_trig_redirect u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .eof(eof),
    .next_addr(next_addr), .start_addr(start_addr),
    .start_pulse(start_pulse), .redir_pending(redir_pending),
    .fetch_valid(fetch_valid), .fetch_redirect(fetch_redirect),
    .fetch_addr(fetch_addr)
  );

  // Behavioural reference: per-channel state in plain arrays
  bit          m_pend  [NCH];
  bit          m_pulse [NCH];
  bit          m_fv    [NCH];
  bit          m_redir [NCH];
  logic [31:0] m_addr  [NCH];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        m_pend[i] = 0; m_pulse[i] = 0; m_fv[i] = 0; m_redir[i] = 0; m_addr[i] = '0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        bit wr_t, wr_r;
        wr_t = wr_en && wr_data[i];
        wr_r = wr_en && wr_data[NCH+i];
        m_pulse[i] = wr_t;
        m_fv[i]    = eof[i];
        if (eof[i]) begin
          m_redir[i] = m_pend[i];
          m_addr[i]  = m_pend[i] ? start_addr[i*AW +: AW] : next_addr[i*AW +: AW];
          m_pend[i]  = 0;
        end
        if (wr_r) m_pend[i] = 1;
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (model_on && !done) begin
      for (int i = 0; i < NCH; i++) begin
        chk(start_pulse[i] == m_pulse[i], "R2 start pulse", start_pulse[i], m_pulse[i]);
        chk(redir_pending[i] == m_pend[i], "R4 pending flag", redir_pending[i], m_pend[i]);
        chk(fetch_valid[i] == m_fv[i], "R5 fetch strobe", fetch_valid[i], m_fv[i]);
        if (m_fv[i]) begin
          chk(fetch_redirect[i] == m_redir[i], "R6 fetch source", fetch_redirect[i], m_redir[i]);
          chk(fetch_addr[i*AW +: AW] == m_addr[i], "R6 fetch address", fetch_addr[i*AW +: AW], m_addr[i]);
        end
      end
      chk(rd_data == 32'h0, "R8 read data", rd_data, 0);
    end
  end

  task automatic set_addrs(input int seed);
    for (int i = 0; i < NCH; i++) begin
      next_addr[i*AW +: AW]  = 32'h1000_0000 + 32'(i * 16) + 32'(seed);
      start_addr[i*AW +: AW] = 32'hA000_0000 + 32'(i * 256);
    end
  endtask

  // Drive one cycle of stimulus at the falling edge, return at the next falling edge
  task automatic cyc(input bit w, input logic [31:0] d, input logic [NCH-1:0] e, input bit r);
    @(negedge clk);
    wr_en = w; wr_data = d; eof = e; rd_en = r;
    @(negedge clk);
    #0.1;
    wr_en = 0; wr_data = '0; eof = '0; rd_en = 0;
  endtask

  initial begin
    set_addrs(0);
    repeat (4) @(negedge clk);
    // R1: outputs at rest during reset
    chk(start_pulse == '0 && redir_pending == '0 && fetch_valid == '0 && fetch_redirect == '0,
        "R1 reset outputs", {start_pulse, redir_pending, fetch_valid}, 0);
    chk(fetch_addr == '0 && rd_data == '0, "R1 reset data", rd_data, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(start_pulse == '0 && redir_pending == '0 && fetch_valid == '0, "R1 after release",
        {start_pulse, redir_pending, fetch_valid}, 0);
    model_on = 1;

    // R2: trigger ch3 only, pulse next cycle then gone
    cyc(1, 32'h0000_0008, '0, 0);
    chk(start_pulse == 6'b001000, "R2 trigger ch3", start_pulse, 6'b001000);
    @(negedge clk);
    chk(start_pulse == '0, "R2 pulse one cycle", start_pulse, 0);

    // R3: write of zero, and data without strobe, do nothing
    cyc(1, 32'h0, '0, 0);
    chk(start_pulse == '0 && redir_pending == '0, "R3 zero write", {start_pulse, redir_pending}, 0);
    cyc(0, 32'h0000_0FFF, '0, 0);
    chk(start_pulse == '0 && redir_pending == '0, "R3 no strobe", {start_pulse, redir_pending}, 0);

    // R8: reserved bits only, then a read
    cyc(1, 32'hFFFF_F000, '0, 1);
    chk(start_pulse == '0 && redir_pending == '0 && rd_data == '0, "R8 reserved write",
        {rd_data, start_pulse, redir_pending}, 0);

    // R5: eof on ch1 without pending follows link
    cyc(0, '0, 6'b000010, 0);
    chk(fetch_valid == 6'b000010 && fetch_redirect[1] == 0, "R5 link fetch", fetch_valid, 6'b000010);
    chk(fetch_addr[1*AW +: AW] == 32'h1000_0010, "R5 link addr", fetch_addr[1*AW +: AW], 32'h1000_0010);

    // R4/R6: arm ch2, then consume
    cyc(1, 32'h0000_0100, '0, 0);
    chk(redir_pending == 6'b000100, "R4 arm ch2", redir_pending, 6'b000100);
    repeat (3) @(negedge clk);
    chk(redir_pending == 6'b000100, "R4 flag holds", redir_pending, 6'b000100);
    cyc(0, '0, 6'b000100, 0);
    chk(fetch_redirect[2] == 1 && fetch_addr[2*AW +: AW] == 32'hA000_0200, "R6 redirected fetch",
        fetch_addr[2*AW +: AW], 32'hA000_0200);
    chk(redir_pending[2] == 0, "R6 flag consumed", redir_pending[2], 0);

    // R7: arm, then consume with a fresh request in the same cycle
    cyc(1, 32'h0000_0100, '0, 0);
    cyc(1, 32'h0000_0100, 6'b000100, 0);
    chk(fetch_redirect[2] == 1 && redir_pending[2] == 1, "R7 collision re-arms",
        {fetch_redirect[2], redir_pending[2]}, 2'b11);
    cyc(0, '0, 6'b000100, 0);
    chk(fetch_redirect[2] == 1 && redir_pending[2] == 0, "R7 next frame redirected",
        {fetch_redirect[2], redir_pending[2]}, 2'b10);
    // R7: request arriving with eof while idle does not steer that fetch
    cyc(1, 32'h0000_0200, 6'b001000, 0);
    chk(fetch_redirect[3] == 0 && redir_pending[3] == 1, "R7 late request",
        {fetch_redirect[3], redir_pending[3]}, 2'b01);
    cyc(0, '0, 6'b001000, 0);

    // R9: redirect ch0 only, all channels end frame together
    cyc(1, 32'h0000_0040, '0, 0);
    cyc(0, '0, 6'b111111, 0);
    chk(fetch_valid == 6'b111111 && fetch_redirect == 6'b000001, "R9 independent channels",
        fetch_redirect, 6'b000001);
    chk(fetch_addr[4*AW +: AW] == 32'h1000_0040, "R9 ch4 link addr", fetch_addr[4*AW +: AW], 32'h1000_0040);

    // Random traffic, model compared every cycle
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      set_addrs(n);
      wr_en   = ($urandom_range(0, 2) == 0);
      wr_data = $urandom();
      eof     = NCH'($urandom()) & NCH'($urandom());
      rd_en   = $urandom_range(0, 1);
    end
    @(negedge clk);
    wr_en = 0; eof = '0; rd_en = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule